// File: doc/BRIEF.md
# Keyboard Interrupt Falling-Edge Generator

This block drives an open-drain, active-low keyboard interrupt line toward a host that only reacts to negative edges. Another agent may have left the line low, or it may have been released only a moment ago. Either way, the block never lowers the line straight away. It first keeps the line released for a fixed settle phase, so the external pull-up can bring it high. It then pulls the line low for a fixed assert phase and releases it again. The host therefore always sees a clean high-to-low transition.

There are two ways to start a sequence. The first is a byte written into the keyboard output buffer with the send-interrupt flag set. The second is a resume strobe that arrives while the output buffer-full flag is set. A request that arrives while a sequence is running is latched, and one full new sequence follows the current one. Both phases have the same length: a per-microsecond clock-cycle count multiplied by the phase length in microseconds.

Top module: `kbd_irq_edge_gen`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `irq_pull_low` is 0 (line released). No sequence starts after reset until a trigger is seen.
- R2: A cycle with `obuf_wr_stb`=1 and `obuf_wr_irq`=1 starts one sequence. If that cycle's clock edge is k, `irq_pull_low` stays 0 through edge k+P and rises at edge k+1+P, where P = CYC_PER_US*PHASE_US.
- R3: A cycle with `obuf_wr_stb`=1 and `obuf_wr_irq`=0 starts no sequence, and `irq_pull_low` stays 0.
- R4: A cycle with `resume_stb`=1 while `obuf_full`=1 starts one sequence, with the same timing as R2.
- R5: A cycle with `resume_stb`=1 while `obuf_full`=0 starts no sequence.
- R6: A trigger that arrives while a sequence is running is held. It starts a full new sequence whose settle phase begins one cycle after the running sequence returns to idle. For a first sequence whose settle phase starts at edge S, the second sequence's low phase therefore begins at edge S+3P+1.
- R7: Any number of triggers received while a sequence is running produce exactly one following sequence.
- R8: Every low phase lasts exactly P cycles. Every low phase is preceded by at least P cycles with the line released.
- R9: Asserting `rst` during a sequence releases the line at the next edge and discards any held trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| obuf_wr_stb | input | 1 | One-cycle pulse: a byte was written to the output buffer |
| obuf_wr_irq | input | 1 | Send-interrupt flag that accompanies `obuf_wr_stb` |
| resume_stb | input | 1 | One-cycle pulse: interrupts are being resumed |
| obuf_full | input | 1 | Level: the output buffer holds an unread byte |
| irq_pull_low | output | 1 | Open-drain enable: 1 pulls the interrupt line low, 0 releases it |

## Verification
If the phase counter is stuck or off by one, the error shows at the very next falling edge. That edge starts at the wrong cycle, and the low phase that follows is longer or shorter than P. Both appear within 2P cycles of the trigger.

A lost or stuck held-trigger flag shows up only when requests overlap. Either the second sequence is missing one cycle after the first one ends, or an extra sequence appears after quiet stimulus. The bench therefore overlaps triggers at the ends of both phases.

A sequencer that wakes in the wrong state after reset shows a low pulse without any trigger. It does so within P+1 cycles of reset release.

// File: rtl/kirq_pkg.sv
package kirq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REL  = 2'd1,
    SEQ_LOW  = 2'd2
  } seq_st_e;

endpackage

// File: rtl/kirq_trigger.sv
module kirq_trigger (
  input  logic clk,
  input  logic rst,
  input  logic obuf_wr_stb,
  input  logic obuf_wr_irq,
  input  logic resume_stb,
  input  logic obuf_full,
  input  logic take,
  output logic pend_q
);

  logic wr_req;
  logic res_req;
  logic req;

  assign wr_req  = obuf_wr_stb & obuf_wr_irq;
  assign res_req = resume_stb & obuf_full;
  assign req     = wr_req | res_req;

  // A single held flag: overlapping requests merge into one later sequence.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= req | (pend_q & ~take);
  end

  p_write_irq_held_r2: assert property (@(posedge clk) disable iff (rst)
    (obuf_wr_stb && obuf_wr_irq) |=> pend_q);

  p_quiet_write_r3: assert property (@(posedge clk) disable iff (rst)
    (obuf_wr_stb && !obuf_wr_irq && !resume_stb && !pend_q) |=> !pend_q);

  p_resume_full_held_r4: assert property (@(posedge clk) disable iff (rst)
    (resume_stb && obuf_full) |=> pend_q);

  p_quiet_resume_r5: assert property (@(posedge clk) disable iff (rst)
    (resume_stb && !obuf_full && !obuf_wr_stb && !pend_q) |=> !pend_q);

endmodule

// File: rtl/kirq_phase_timer.sv
module kirq_phase_timer #(
  parameter int PHASE_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic phase_done
);

  generate
    if (PHASE_CYC <= 1) begin : g_single
      assign phase_done = run;
    end else begin : g_count
      localparam int CW = $clog2(PHASE_CYC);
      localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
        if (rst || restart)              cnt <= '0;
        else if (run && (cnt != LAST))   cnt <= cnt + 1'b1;
      end

      assign phase_done = run && (cnt == LAST);

      p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    end
  endgenerate

endmodule

// File: rtl/kirq_sequencer.sv
module kirq_sequencer
  import kirq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pend,
  input  logic phase_done,
  output logic take,
  output logic restart,
  output logic run,
  output logic pull_low
);

  seq_st_e st;
  seq_st_e st_n;

  always_comb begin
    st_n    = st;
    take    = 1'b0;
    restart = 1'b0;
    unique case (st)
      SEQ_IDLE: if (pend) begin
        st_n    = SEQ_REL;
        take    = 1'b1;
        restart = 1'b1;
      end
      SEQ_REL: if (phase_done) begin
        st_n    = SEQ_LOW;
        restart = 1'b1;
      end
      SEQ_LOW: if (phase_done) st_n = SEQ_IDLE;
      default: st_n = SEQ_IDLE;
    endcase
  end

  assign run = (st != SEQ_IDLE);

  // Registered open-drain enable, taken from the next state.
  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SEQ_IDLE;
      pull_low <= 1'b0;
    end else begin
      st       <= st_n;
      pull_low <= (st_n == SEQ_LOW);
    end
  end

  p_low_after_release_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low) |-> ($past(st) == SEQ_REL));

  p_take_only_idle_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> (st == SEQ_REL && !pull_low));

endmodule

// File: rtl/kbd_irq_edge_gen.sv
module kbd_irq_edge_gen #(
  parameter int CYC_PER_US = 250,
  parameter int PHASE_US   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic obuf_wr_stb,
  input  logic obuf_wr_irq,
  input  logic resume_stb,
  input  logic obuf_full,
  output logic irq_pull_low
);

  localparam int PHASE_CYC = CYC_PER_US * PHASE_US;
  localparam int RW        = $clog2(PHASE_CYC + 1);
  localparam logic [RW-1:0] RSAT = RW'(PHASE_CYC);

  logic pend;
  logic take;
  logic restart;
  logic run;
  logic phase_done;

  kirq_trigger u_trig (
    .clk         (clk),
    .rst         (rst),
    .obuf_wr_stb (obuf_wr_stb),
    .obuf_wr_irq (obuf_wr_irq),
    .resume_stb  (resume_stb),
    .obuf_full   (obuf_full),
    .take        (take),
    .pend_q      (pend)
  );

  kirq_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .restart    (restart),
    .phase_done (phase_done)
  );

  kirq_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .pend       (pend),
    .phase_done (phase_done),
    .take       (take),
    .restart    (restart),
    .run        (run),
    .pull_low   (irq_pull_low)
  );

  // Run-length monitors of the output line, used only by the checks below.
  logic [RW-1:0] rel_run;
  logic [RW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_run <= '0;
      low_run <= '0;
    end else begin
      rel_run <= irq_pull_low ? '0 : ((rel_run == RSAT) ? rel_run : rel_run + 1'b1);
      low_run <= !irq_pull_low ? '0 : ((low_run == RSAT) ? low_run : low_run + 1'b1);
    end
  end

  p_reset_released_r1: assert property (@(posedge clk)
    rst |=> !irq_pull_low);

  p_low_max_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pull_low |-> (low_run < RSAT));

  p_low_exact_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_pull_low) |-> (low_run == RSAT));

  p_settle_first_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pull_low) |-> (rel_run >= RSAT));

endmodule

// File: tb/kbd_irq_edge_gen_tb_top.sv
module kbd_irq_edge_gen_tb_top;

  localparam int CPU = 2;
  localparam int PUS = 4;
  localparam int P   = CPU * PUS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0, wirq = 1'b0, res = 1'b0, full = 1'b0;
  logic pull;

  always #2 clk = ~clk;

  kbd_irq_edge_gen #(.CYC_PER_US(CPU), .PHASE_US(PUS)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .obuf_wr_stb  (wr),
    .obuf_wr_irq  (wirq),
    .resume_stb   (res),
    .obuf_full    (full),
    .irq_pull_low (pull)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  typedef struct {
    int    at;
    string tag;
  } exp_t;

  exp_t  q[$];
  exp_t  e;
  int    last_s = -1000;
  string quiet_tag = "R1";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the expected low-phase start cycle on each falling edge
  // of the line and measures the low phase width.
  logic prev = 1'b0;
  int   width = 0;
  bit   in_low = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      in_low = 1'b0;
      prev   = pull;
    end else begin
      if (pull && !prev) begin
        if (q.size() == 0) begin
          chk(1'b0, quiet_tag, "unexpected low phase at cycle", cyc, -1);
        end else begin
          e = q.pop_front();
          chk(cyc == e.at, e.tag, "low phase start cycle", cyc, e.at);
        end
        in_low = 1'b1;
        width  = 1;
      end else if (pull && in_low) begin
        width++;
      end else if (!pull && prev && in_low) begin
        chk(width == P, "R8", "low phase width", width, P);
        in_low = 1'b0;
      end
      prev = pull;
    end
  end

  // Driver: called at a falling clock edge; the edge that samples it is k.
  task automatic stim(bit w, bit wi, bit r, bit f, string tag);
    int k;
    int s;
    wr = w; wirq = wi; res = r; full = f;
    k = cyc + 1;
    if ((w && wi) || (r && f)) begin
      if (k >= last_s) begin
        s = (k + 1 > last_s + 2*P + 1) ? k + 1 : last_s + 2*P + 1;
        q.push_back('{s + P, tag});
        last_s = s;
      end
    end else begin
      quiet_tag = tag;
    end
    @(negedge clk);
    wr = 1'b0; wirq = 1'b0; res = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(string tag);
    rst = 1'b1;
    @(negedge clk);
    chk(pull == 1'b0, tag, "line during reset", pull, 0);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    last_s = -1000;
    quiet_tag = tag;
  endtask

  initial begin
    int s0;
    idle(3);
    chk(pull == 1'b0, "R1", "line in reset", pull, 0);
    rst = 1'b0;
    idle(3*P);
    chk(pull == 1'b0, "R1", "line after reset, no trigger", pull, 0);

    // R2: write with interrupt flag
    stim(1, 1, 0, 0, "R2");
    idle(2*P + 6);

    // R3: write without interrupt flag
    stim(1, 0, 0, 0, "R3");
    idle(2*P + 6);
    chk(pull == 1'b0, "R3", "line after plain write", pull, 0);
    chk(q.size() == 0, "R3", "pending expectations", q.size(), 0);

    // R4: resume with buffer full
    stim(0, 0, 1, 1, "R4");
    idle(2*P + 6);

    // R5: resume with buffer empty
    stim(0, 0, 1, 0, "R5");
    idle(2*P + 6);
    chk(pull == 1'b0, "R5", "line after empty resume", pull, 0);

    // R6: trigger during the low phase
    stim(1, 1, 0, 1, "R6");
    idle(P + 2);
    stim(0, 0, 1, 1, "R6");
    idle(4*P + 8);

    // R6 boundary: trigger on the last edge of the low phase
    stim(1, 1, 0, 0, "R6");
    s0 = last_s;
    while (cyc + 1 != s0 + 2*P - 1) @(negedge clk);
    stim(1, 1, 0, 0, "R6");
    idle(4*P + 8);

    // R6 boundary: trigger one edge after return to idle
    stim(1, 1, 0, 0, "R6");
    s0 = last_s;
    while (cyc + 1 != s0 + 2*P + 1) @(negedge clk);
    stim(1, 1, 0, 0, "R6");
    idle(4*P + 8);

    // R7: several triggers in one sequence collapse into one
    stim(1, 1, 0, 0, "R7");
    idle(2);
    stim(1, 1, 0, 0, "R7");
    idle(2);
    stim(0, 0, 1, 1, "R7");
    idle(P);
    stim(1, 1, 0, 0, "R7");
    idle(5*P + 8);
    chk(q.size() == 0, "R7", "pending expectations", q.size(), 0);

    // R9: reset during the low phase with a held trigger
    stim(1, 1, 0, 0, "R9");
    idle(P + 3);
    stim(1, 1, 0, 0, "R9");
    do_reset("R9");
    chk(pull == 1'b0, "R9", "line right after reset", pull, 0);
    idle(4*P);
    chk(pull == 1'b0, "R9", "held trigger discarded", pull, 0);

    // After reset the block works again (R1/R2)
    stim(1, 1, 0, 0, "R2");
    idle(2*P + 6);
    chk(q.size() == 0, "R2", "unserved expectations", q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule